// File: doc/BRIEF.md
# Timing Activity Monitor with Error Masking

This block sits behind a line receiver that delivers a bare timing pulse stream alongside received data. It watches that stream for rising edges and, when they stop arriving for a programmable number of system clocks, declares the timing out of tolerance. Losing timing does more than raise an alarm. The outgoing data bit is forced low, the stuff-comparator error flag is held in its no-error state, and the data-compare error is kept away from the combined error output. Errors that would be meaningless without timing therefore never reach the rest of the system.

The timing input is asynchronous to the system clock. It passes through a two-stage synchronizer and an edge detector, which refresh an idle counter. The first valid edge after a loss restores activity and removes all masking. The out-of-tolerance output is the inverse of the activity state and is intended for a status display.

Top module: `timing_watch`

## Requirements
- R1: While reset is held, and after reset until the first timing edge takes effect, outOfTol is 1, gatedData is 0 and errOut is 0.
- R2: A rising edge on timingIn, sampled high at clock edge t after being sampled low at edge t-1, makes the block active from clock edge t+2, because of the two synchronizer stages and the edge register.
- R3: Once active, the block stays active until LOSS_LIMIT clock edges have passed since the last edge at which a timing rise took effect. It drops at that edge unless a new rise takes effect at the same edge, in which case it stays active. The default LOSS_LIMIT is 16, which is 4 bit periods of 4 clocks each.
- R4: gatedData equals dataIn while active and is 0 while not active, combinationally from dataIn.
- R5: outOfTol is 1 exactly when the block is not active.
- R6: A stuffErrStrobe sampled at a clock edge while the block is active raises the stuff error for the following cycle only. A strobe sampled while inactive never raises it, including in the first active cycle after a restore.
- R7: While active, cmpErrIn reaches errOut combinationally in the same cycle. While inactive it has no effect on errOut.
- R8: errOut is the OR of the registered stuff error path and the data-compare path, and it is 0 whenever the block is inactive.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| timingIn | input | 1 | Timing pulse stream from the receiver, asynchronous |
| stuffErrStrobe | input | 1 | Error strobe from the stuff comparator |
| cmpErrIn | input | 1 | Data-compare error level |
| dataIn | input | 1 | Data bit from the buffer output register |
| gatedData | output | 1 | Data bit, forced to 0 while timing is missing |
| outOfTol | output | 1 | Timing out-of-tolerance status for the display |
| errOut | output | 1 | Combined error, masked while timing is missing |

## Verification
Activity follows a sampled timing rise by two clock edges and falls LOSS_LIMIT edges after the last effective rise. gatedData, outOfTol and the compare part of errOut follow the activity register and the inputs in the same cycle, while the stuff part of errOut appears one edge after its strobe. A reference model in the bench advances at every rising edge and pushes one expected output set into a queue. Each set is compared at the following falling edge, after that edge's register updates and before the driver changes the inputs. The stimulus uses timing gaps one shorter than the limit, exactly at it and one longer, and places strobes and compare errors during loss, on the cycle of restore and during normal activity.

// File: rtl/timing_watch_pkg.sv
package timing_watch_pkg;
  // Strobes passed from control to datapath
  typedef struct packed {
    logic active;  // timing present
    logic rise;    // synchronized timing rise seen this cycle
  } tmStrobe_t;
endpackage

// File: rtl/timing_watch_ctrl.sv
module timing_watch_ctrl
  import timing_watch_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int LOSS_LIMIT  = 16
) (
  input  logic      clk,
  input  logic      rstN,
  input  logic      timingIn,
  output tmStrobe_t strb
);
  localparam int CNT_W = $clog2(LOSS_LIMIT + 1);
  localparam logic [CNT_W-1:0] LAST_CNT = CNT_W'(LOSS_LIMIT - 1);

  // synchronizer stages plus one extra stage for edge detection
  logic [SYNC_STAGES:0] syncChain;
  logic [CNT_W-1:0]     idleCnt;
  logic                 activeQ;
  logic                 riseNow;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) syncChain <= '0;
    else       syncChain <= {syncChain[SYNC_STAGES-1:0], timingIn};
  end

  assign riseNow = syncChain[SYNC_STAGES-1] & ~syncChain[SYNC_STAGES];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      idleCnt <= LAST_CNT;
      activeQ <= 1'b0;
    end else if (riseNow) begin
      idleCnt <= '0;
      activeQ <= 1'b1;
    end else if (idleCnt == LAST_CNT) begin
      activeQ <= 1'b0;
    end else begin
      idleCnt <= idleCnt + 1'b1;
    end
  end

  assign strb.active = activeQ;
  assign strb.rise   = riseNow;

  AST_RISE_ACTIVATES: assert property (@(posedge clk) disable iff (!rstN)
    riseNow |=> activeQ); // R2
  AST_DROP_ONLY_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    $fell(activeQ) |-> $past(!riseNow)); // R3
  AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!rstN)
    idleCnt <= LAST_CNT); // R3
endmodule

// File: rtl/timing_watch_dp.sv
module timing_watch_dp
  import timing_watch_pkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  tmStrobe_t strb,
  input  logic      stuffErrStrobe,
  input  logic      cmpErrIn,
  input  logic      dataIn,
  output logic      gatedData,
  output logic      outOfTol,
  output logic      errOut
);
  logic stuffErrQ;
  logic cmpErrMasked;

  // stuff error flag: held in its no-error state while timing is missing
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)            stuffErrQ <= 1'b0;
    else if (!strb.active) stuffErrQ <= 1'b0;
    else                  stuffErrQ <= stuffErrStrobe;
  end

  assign cmpErrMasked = cmpErrIn & strb.active;
  assign gatedData    = dataIn & strb.active;
  assign outOfTol     = ~strb.active;
  assign errOut       = (stuffErrQ & strb.active) | cmpErrMasked;

  AST_GATE_LOW: assert property (@(posedge clk) disable iff (!rstN)
    outOfTol |-> !gatedData); // R4
  AST_STUFF_PRESET: assert property (@(posedge clk) disable iff (!rstN)
    $past(!strb.active) |-> !stuffErrQ); // R6
  AST_ERR_MASKED: assert property (@(posedge clk) disable iff (!rstN)
    outOfTol |-> !errOut); // R8
  AST_CMP_PASS: assert property (@(posedge clk) disable iff (!rstN)
    (!outOfTol && cmpErrIn) |-> errOut); // R7
endmodule

// File: rtl/timing_watch.sv
module timing_watch
  import timing_watch_pkg::*;
#(
  parameter int BIT_CLKS  = 4,
  parameter int LOSS_BITS = 4
) (
  input  logic clk,
  input  logic rstN,
  input  logic timingIn,
  input  logic stuffErrStrobe,
  input  logic cmpErrIn,
  input  logic dataIn,
  output logic gatedData,
  output logic outOfTol,
  output logic errOut
);
  localparam int LOSS_LIMIT = BIT_CLKS * LOSS_BITS;

  tmStrobe_t strb;

  timing_watch_ctrl #(.SYNC_STAGES(2), .LOSS_LIMIT(LOSS_LIMIT)) u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .timingIn (timingIn),
    .strb     (strb)
  );

  timing_watch_dp u_dp (
    .clk            (clk),
    .rstN           (rstN),
    .strb           (strb),
    .stuffErrStrobe (stuffErrStrobe),
    .cmpErrIn       (cmpErrIn),
    .dataIn         (dataIn),
    .gatedData      (gatedData),
    .outOfTol       (outOfTol),
    .errOut         (errOut)
  );

  AST_RESET_OOT: assert property (@(posedge clk)
    !rstN |=> (outOfTol || rstN)); // R1
endmodule

// File: tb/timing_watch_tb.sv
module timing_watch_tb;
  localparam int CLK_PERIOD = 10;
  localparam int LIMIT      = 16;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic timingIn = 1'b0;
  logic stuffErrStrobe = 1'b0;
  logic cmpErrIn = 1'b0;
  logic dataIn = 1'b0;
  logic gatedData, outOfTol, errOut;

  int checks = 0;
  int fails  = 0;
  string curTag = "R1";

  typedef struct { logic g; logic o; logic e; string tag; } exp_t;
  exp_t sb[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  timing_watch #(.BIT_CLKS(4), .LOSS_BITS(4)) u_dut (
    .clk(clk), .rstN(rstN), .timingIn(timingIn),
    .stuffErrStrobe(stuffErrStrobe), .cmpErrIn(cmpErrIn), .dataIn(dataIn),
    .gatedData(gatedData), .outOfTol(outOfTol), .errOut(errOut)
  );

  // reference model from the requirements (R2, R3 timing; R4..R8 outputs)
  int  cycN = 0;
  int  lastEff = 0;
  bit  haveEff = 0;
  bit  h1 = 0, h2 = 0, h3 = 0;
  always @(posedge clk) begin
    exp_t it;
    bit actPrev, actNow, stuffExp;
    cycN++;
    if (!rstN) begin
      haveEff = 0; h1 = 0; h2 = 0; h3 = 0;
      it.g = 0; it.o = 1; it.e = 0; it.tag = "R1";
    end else begin
      actPrev = haveEff && ((cycN - 1 - lastEff) < LIMIT);
      if (h2 && !h3) begin haveEff = 1; lastEff = cycN; end
      h3 = h2; h2 = h1; h1 = timingIn;
      actNow   = haveEff && ((cycN - lastEff) < LIMIT);
      stuffExp = actPrev && stuffErrStrobe;
      it.g = actNow && dataIn;
      it.o = !actNow;
      it.e = actNow && (stuffExp || cmpErrIn);
      it.tag = curTag;
    end
    sb.push_back(it);
  end

  // monitor: compare at the falling edge, before the driver moves inputs
  always @(negedge clk) begin
    exp_t it;
    #1;
    if (sb.size() > 0) begin
      it = sb.pop_front();
      checks++;
      if (gatedData !== it.g) begin
        fails++;
        $display("FAIL R4 (%s) gatedData actual=%b expected=%b", it.tag, gatedData, it.g);
      end
      checks++;
      if (outOfTol !== it.o) begin
        fails++;
        $display("FAIL R5 (%s) outOfTol actual=%b expected=%b", it.tag, outOfTol, it.o);
      end
      checks++;
      if (errOut !== it.e) begin
        fails++;
        $display("FAIL R8 (%s) errOut actual=%b expected=%b", it.tag, errOut, it.e);
      end
    end
  end

  task automatic waitCyc(input int n);
    repeat (n) begin @(negedge clk); #2; end
  endtask

  // driver: timing pulses with given period, toggling data and errors
  task automatic pulses(input int period, input int count, input bit errs);
    for (int p = 0; p < count; p++) begin
      for (int c = 0; c < period; c++) begin
        timingIn       = (c < 2);
        dataIn         = ((c + p) % 3) != 0;
        stuffErrStrobe = errs && (c == 3);
        cmpErrIn       = errs && (c == 5);
        waitCyc(1);
      end
    end
    timingIn = 0; stuffErrStrobe = 0; cmpErrIn = 0;
  endtask

  bit done = 0;
  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    // R1: reset state and idle without timing, with inputs toggling
    curTag = "R1";
    dataIn = 1; cmpErrIn = 1; stuffErrStrobe = 1;
    waitCyc(4);
    rstN = 1;
    waitCyc(6);
    dataIn = 0; cmpErrIn = 0; stuffErrStrobe = 0;
    waitCyc(2);
    // R2: first edge activates after the synchronizer delay
    curTag = "R2";
    pulses(8, 2, 1'b0);
    // R4 R6 R7: data gating and error paths during normal activity
    curTag = "R4 R6 R7";
    pulses(8, 4, 1'b1);
    // R3: stop pulses, activity drops after LOSS_LIMIT clocks
    curTag = "R3";
    waitCyc(LIMIT + 4);
    // R6 R7: errors during loss must be masked
    curTag = "R6 R7 loss";
    dataIn = 1; cmpErrIn = 1; stuffErrStrobe = 1;
    waitCyc(5);
    // R6: restore with strobe held across the restore edge
    curTag = "R6 restore";
    timingIn = 1; waitCyc(2); timingIn = 0;
    waitCyc(3);
    stuffErrStrobe = 0; cmpErrIn = 0;
    waitCyc(2);
    // R3 boundary: gap one short of, equal to, and one past the limit
    curTag = "R3 gap15";
    pulses(LIMIT - 1, 3, 1'b1);
    curTag = "R3 gap16";
    pulses(LIMIT, 3, 1'b1);
    curTag = "R3 gap17";
    pulses(LIMIT + 1, 3, 1'b1);
    curTag = "R8 mix";
    pulses(5, 6, 1'b1);
    waitCyc(LIMIT + 6);
    // R1: reset asserted mid-activity returns to reset state
    curTag = "R1 reapply";
    pulses(6, 2, 1'b0);
    rstN = 0;
    waitCyc(3);
    rstN = 1;
    waitCyc(4);
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule